// File: doc/BRIEF.md
# Dual-Modulus Swallow Divider

This block is the digital counting stage of a frequency synthesizer loop. It runs on a clock taken from the oscillator side of the loop. In direct mode that clock is the oscillator itself; in the two prescaled modes it is the output of an external dual-modulus prescaler. The block emits one divided pulse per programmed period, and that pulse goes to the phase comparator. In the prescaled modes the block also drives the modulus-control line of the prescaler. The prescaler is therefore divided by P+1 for the first A counts of each period and by P for the rest. The total division from the oscillator is N = P*M + A, where M is the main count and A is the swallow count.

A host writes the division value N, up to 17 bits, into staging registers through a simple byte-wide write port. The staged value does nothing until the host writes a 1 to the transfer bit. That write captures the staged N together with the mode input. The captured setting replaces the running one only at the next terminal count, so an output period is never cut short. Any N below the minimum a mode can realise is raised to that minimum.

Top module: `swallow_divider`

## Requirements
- R1: After reset `div_pulse` and `mod_ctl` are low, and the block divides in direct mode by `RST_DIV` (default 208): the first pulse appears 208 clocks after reset is released, and the period is 208 clocks.
- R2: A write with `wr_addr` 0 sets staged N[7:0], address 1 sets N[15:8], and address 2 sets N[16] from `wr_data` bit 0. Writing the staging registers alone changes neither the period nor `mod_ctl`.
- R3: A write to address 3 with `wr_data` bit 0 = 1 captures the staged N and the `div_mode` input. A write to address 3 with bit 0 = 0 is ignored. A change of `div_mode` without such a transfer has no effect.
- R4: A captured setting takes effect at the next terminal count. The period in progress completes with the old value, and every later period uses the new value.
- R5: `div_mode` 00 (and the spare code 11) selects direct division. The period is N[11:0] clocks, `mod_ctl` stays low, and N[16:12] is ignored.
- R6: `div_mode` 01 selects prescaler modulus 16. The period is M = N[15:4] clocks, and `mod_ctl` is high for the first A = N[3:0] clocks of each period, starting in the pulse cycle. N[16] is ignored.
- R7: `div_mode` 10 selects prescaler modulus 32. The period is M = N[16:5] clocks, and `mod_ctl` is high for the first A = N[4:0] clocks of each period.
- R8: An N below the minimum of its mode is raised to that minimum before use: 2 in direct mode, 240 (16*15) for modulus 16, and 992 (32*31) for modulus 32.
- R9: `div_pulse` is exactly one clock wide, once per period. `mod_ctl` can only rise in a pulse cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divider input clock (oscillator or prescaler output) |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host register select: 0 low byte, 1 high byte, 2 extension bit, 3 transfer |
| wr_data | input | 8 | Host write data |
| div_mode | input | 2 | Division mode, captured on transfer: 00 direct, 01 modulus 16, 10 modulus 32, 11 direct |
| div_pulse | output | 1 | One-clock pulse at each terminal count, to the phase comparator |
| mod_ctl | output | 1 | Prescaler modulus control: 1 selects P+1, 0 selects P |

## Verification
A register write lands on the clock edge it is presented at. A transfer, however, governs only the period that starts at the first terminal count after that edge. If the transfer lands on the very edge of a terminal count, the new value is one period later still. For that reason the bench discards the period that follows the first pulse after each transfer and measures the next full period. It measures in clocks from one pulse to the next, and it counts the `mod_ctl`-high clocks within that span, starting in the pulse cycle. All sampling is done on the falling clock edge. The first pulse after reset is due exactly `RST_DIV` edges after release. The no-shortening test counts every clock edge of the period across which the transfer is written.

// File: rtl/sdv_pkg.sv
package sdv_pkg;

    localparam int BYTE_W = 8;
    localparam int MAIN_W = 12;
    localparam int SW_W   = 5;
    localparam int N_W    = MAIN_W + SW_W;
    localparam int EXT_W  = N_W - 2 * BYTE_W;

    localparam logic [1:0] ADDR_LO   = 2'd0;
    localparam logic [1:0] ADDR_HI   = 2'd1;
    localparam logic [1:0] ADDR_EXT  = 2'd2;
    localparam logic [1:0] ADDR_XFER = 2'd3;

    typedef enum logic [1:0] {
        MODE_DIRECT = 2'b00,
        MODE_P16    = 2'b01,
        MODE_P32    = 2'b10,
        MODE_SPARE  = 2'b11
    } div_mode_e;

    typedef struct packed {
        logic [MAIN_W-1:0] main;
        logic [SW_W-1:0]   swal;
        logic              presc;
    } div_load_t;

endpackage

// File: rtl/sdv_stage.sv
module sdv_stage
    import sdv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_addr,
    input  logic [BYTE_W-1:0]    wr_data,
    input  div_mode_e            mode_in,
    input  logic                 take,
    output logic                 pend,
    output logic [N_W-1:0]       snap_n,
    output div_mode_e            snap_mode
);

    typedef struct packed {
        logic [N_W-1:0] stg;
        logic [N_W-1:0] snap;
        div_mode_e      mode;
        logic           pend;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // the counter consumed the pending setting at a terminal count
        if (take) begin
            st_d.pend = 1'b0;
        end
        if (wr_en) begin
            unique case (wr_addr)
                ADDR_LO:  st_d.stg[BYTE_W-1:0]        = wr_data;
                ADDR_HI:  st_d.stg[2*BYTE_W-1:BYTE_W] = wr_data;
                ADDR_EXT: st_d.stg[N_W-1:2*BYTE_W]    = wr_data[EXT_W-1:0];
                default: begin
                    if (wr_data[0]) begin
                        // a fresh transfer wins over a simultaneous take
                        st_d.snap = st_q.stg;
                        st_d.mode = mode_in;
                        st_d.pend = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{stg: '0, snap: '0, mode: MODE_DIRECT, pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pend      = st_q.pend;
    assign snap_n    = st_q.snap;
    assign snap_mode = st_q.mode;

endmodule

// File: rtl/sdv_decode.sv
module sdv_decode
    import sdv_pkg::*;
#(
    parameter int LO_PLOG = 4,
    parameter int HI_PLOG = SW_W,
    parameter int DIR_MIN = 2
) (
    input  logic [N_W-1:0] n_in,
    input  div_mode_e      mode,
    output div_load_t      ld
);

    localparam int LO_P     = 1 << LO_PLOG;
    localparam int HI_P     = 1 << HI_PLOG;
    localparam int LO_FIELD = LO_PLOG + MAIN_W;
    localparam int HI_FIELD = HI_PLOG + MAIN_W;
    localparam int LO_MIN   = LO_P * (LO_P - 1);
    localparam int HI_MIN   = HI_P * (HI_P - 1);
    localparam logic [N_W-1:0] LO_MASK = N_W'((1 << LO_FIELD) - 1);
    localparam logic [N_W-1:0] HI_MASK = N_W'((1 << HI_FIELD) - 1);

    logic [MAIN_W-1:0] dir_v;
    logic [N_W-1:0]    lo_v;
    logic [N_W-1:0]    hi_v;

    always_comb begin
        // each mode sees only the N field it can realise, raised to its minimum
        dir_v = n_in[MAIN_W-1:0];
        if (dir_v < MAIN_W'(DIR_MIN)) begin
            dir_v = MAIN_W'(DIR_MIN);
        end
        lo_v = n_in & LO_MASK;
        if (lo_v < N_W'(LO_MIN)) begin
            lo_v = N_W'(LO_MIN);
        end
        hi_v = n_in & HI_MASK;
        if (hi_v < N_W'(HI_MIN)) begin
            hi_v = N_W'(HI_MIN);
        end

        ld = '0;
        unique case (mode)
            MODE_P16: begin
                ld.main  = MAIN_W'(lo_v >> LO_PLOG);
                ld.swal  = SW_W'(lo_v & N_W'(LO_P - 1));
                ld.presc = 1'b1;
            end
            MODE_P32: begin
                ld.main  = MAIN_W'(hi_v >> HI_PLOG);
                ld.swal  = SW_W'(hi_v & N_W'(HI_P - 1));
                ld.presc = 1'b1;
            end
            default: begin
                ld.main  = dir_v;
                ld.swal  = '0;
                ld.presc = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sdv_count.sv
module sdv_count
    import sdv_pkg::*;
#(
    parameter int RST_DIV = 208
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pend,
    input  div_load_t pend_ld,
    output logic      take,
    output logic      pulse,
    output logic      mod_ctl
);

    typedef struct packed {
        logic [MAIN_W-1:0] cnt;
        logic [SW_W-1:0]   sw;
        logic              pulse;
        div_load_t         act;
    } count_t;

    localparam logic [MAIN_W-1:0] RST_M = MAIN_W'(RST_DIV);

    count_t ct_d, ct_q;
    div_load_t next_ld;
    logic terminal;

    always_comb begin
        ct_d     = ct_q;
        terminal = (ct_q.cnt <= MAIN_W'(1));
        next_ld  = pend ? pend_ld : ct_q.act;
        take     = 1'b0;
        if (terminal) begin
            // reload both counters together so a period is never shortened
            ct_d.act   = next_ld;
            ct_d.cnt   = next_ld.main;
            ct_d.sw    = next_ld.swal;
            ct_d.pulse = 1'b1;
            take       = pend;
        end else begin
            ct_d.cnt   = ct_q.cnt - 1'b1;
            ct_d.sw    = (ct_q.sw != '0) ? ct_q.sw - 1'b1 : '0;
            ct_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ct_q <= '{cnt: RST_M, sw: '0, pulse: 1'b0,
                      act: '{main: RST_M, swal: '0, presc: 1'b0}};
        end else begin
            ct_q <= ct_d;
        end
    end

    assign pulse   = ct_q.pulse;
    assign mod_ctl = ct_q.act.presc & (ct_q.sw != '0);

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
    import sdv_pkg::*;
#(
    parameter int RST_DIV = 208,
    parameter int LO_PLOG = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [1:0]  div_mode,
    output logic        div_pulse,
    output logic        mod_ctl
);

    logic           xfer_pend;
    logic           xfer_take;
    logic [N_W-1:0] snap_n;
    div_mode_e      snap_mode;
    div_load_t      pend_ld;

    sdv_stage u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .mode_in   (div_mode_e'(div_mode)),
        .take      (xfer_take),
        .pend      (xfer_pend),
        .snap_n    (snap_n),
        .snap_mode (snap_mode)
    );

    sdv_decode #(
        .LO_PLOG (LO_PLOG),
        .HI_PLOG (SW_W),
        .DIR_MIN (2)
    ) u_decode (
        .n_in (snap_n),
        .mode (snap_mode),
        .ld   (pend_ld)
    );

    sdv_count #(
        .RST_DIV (RST_DIV)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (xfer_pend),
        .pend_ld (pend_ld),
        .take    (xfer_take),
        .pulse   (div_pulse),
        .mod_ctl (mod_ctl)
    );

endmodule

// File: rtl/sdv_chk.sv
module sdv_chk
    import sdv_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic       xfer_bit,
    input logic       div_pulse,
    input logic       mod_ctl,
    input logic       pend
);

    logic [15:0] gap_q;
    logic        seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (div_pulse) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != 16'hFFFF) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    assert_modctl_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_ctl) |-> div_pulse);

    assert_min_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (div_pulse && seen_q) |-> (gap_q != '0));

    assert_stage_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != ADDR_XFER && !pend) |=> !pend);

    assert_xfer_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_XFER && !xfer_bit && !pend) |=> !pend);

    assert_xfer_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_XFER && xfer_bit) |=> pend);

    assert_apply_at_tc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend) |-> div_pulse);

endmodule

bind swallow_divider sdv_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .xfer_bit  (wr_data[0]),
    .div_pulse (div_pulse),
    .mod_ctl   (mod_ctl),
    .pend      (xfer_pend)
);

// File: tb/swallow_divider_tb_top.sv
module swallow_divider_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] div_mode = 2'b00;
    logic       div_pulse;
    logic       mod_ctl;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    swallow_divider dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .div_mode  (div_mode),
        .div_pulse (div_pulse),
        .mod_ctl   (mod_ctl)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [16:0] n;
        int          len;
        int          mods;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 17'd208,     208,  0},
        '{2'b00, 17'd5,       5,    0},
        '{2'b00, 17'd1,       2,    0},
        '{2'b00, 17'h12345,   837,  0},
        '{2'b01, 17'd1000,    62,   8},
        '{2'b01, 17'd100,     15,   0},
        '{2'b01, 17'h10F0F,   240,  15},
        '{2'b10, 17'd1000,    31,   8},
        '{2'b10, 17'd500,     31,   0},
        '{2'b10, 17'h1FFFF,   4095, 31},
        '{2'b11, 17'd300,     300,  0}
    };
    localparam string TAGS [NV] = '{"R5", "R5", "R8", "R5", "R6", "R8",
                                    "R6", "R7", "R8", "R7", "R5"};

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic program_n(input logic [1:0] m, input logic [16:0] n);
        div_mode = m;
        wr(2'd0, n[7:0]);
        wr(2'd1, n[15:8]);
        wr(2'd2, {7'd0, n[16]});
        wr(2'd3, 8'd1);
    endtask

    task automatic sync_pulse();
        do @(negedge clk); while (!div_pulse);
    endtask

    task automatic measure(output int len, output int mods);
        len = 0;
        mods = 0;
        do begin
            if (mod_ctl) mods++;
            @(negedge clk);
            len++;
        end while (!div_pulse);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int len, mods, first;

        // reset state and first period (R1)
        repeat (3) @(negedge clk);
        check("R1", "pulse in reset", int'(div_pulse), 0);
        check("R1", "mod_ctl in reset", int'(mod_ctl), 0);
        rst_n = 1'b1;
        first = 0;
        do begin @(negedge clk); first++; end while (!div_pulse);
        check("R1", "first pulse delay", first, 208);
        @(negedge clk);
        check("R9", "pulse width", int'(div_pulse), 0);
        while (!div_pulse) @(negedge clk);
        measure(len, mods);
        check("R1", "reset period", len, 208);

        // table of modes and values
        for (int i = 0; i < NV; i++) begin
            program_n(VECS[i].mode, VECS[i].n);
            sync_pulse();
            measure(len, mods);
            measure(len, mods);
            check(TAGS[i], "period", len, VECS[i].len);
            check(TAGS[i], "swallow clocks", mods, VECS[i].mods);
        end

        // new value must not shorten the running period (R4)
        program_n(2'b00, 17'd208);
        sync_pulse();
        measure(len, mods);
        repeat (50) @(negedge clk);
        program_n(2'b00, 17'd100);
        len = 54;
        while (!div_pulse) begin @(negedge clk); len++; end
        check("R4", "period across transfer", len, 208);
        measure(len, mods);
        check("R4", "period after transfer", len, 100);

        // staging write, zero transfer bit and mode change are all ignored (R2, R3)
        wr(2'd0, 8'd77);
        wr(2'd3, 8'd0);
        div_mode = 2'b01;
        sync_pulse();
        measure(len, mods);
        check("R2", "period after staging write", len, 100);
        measure(len, mods);
        check("R3", "period after zero transfer", len, 100);
        check("R3", "mod_ctl after mode change", mods, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule